// File: doc/BRIEF.md
# HDLC Transmit Chunk Sequencer

This block moves one outgoing frame from a byte buffer into a transmit FIFO of limited depth. It works in bursts. Each burst pushes up to one FIFO's worth of bytes, one byte per cycle, while presenting the buffer read address. A single command beat follows each burst. Every command asks the FIFO to start sending. On the burst that empties the frame, the command also marks the end of the message. After each command the block waits for the FIFO to report that its pool has room again.

If the line side reports a transmit underrun or asks for the message to be repeated, the frame position goes back to the frame start, and the next pool-ready event resends the whole frame. The block raises a completion pulse only when a pool-ready event arrives after the last burst. A new frame is taken only while the link is active, only when the block is idle, and only when the length is in range. Any other request is dropped and flagged on the error pulse.

Top module: `hdlc_tx_chunker`

## Requirements
- R1: After reset the block is idle: `busy_o`, `fifo_push_o`, `cmd_valid_o`, `confirm_o` and `err_o` are all 0.
- R2: A request sampled while idle, with `link_active_i` high and a length from 1 to MAX_LEN, is accepted. Pushing starts in the next cycle at `rd_addr_o` = 0, and each push after that raises the address by one.
- R3: When more than DEPTH (32) bytes remain, the block pushes exactly DEPTH bytes. In the following cycle it raises `cmd_valid_o` with `cmd_code_o` = 8'h08 (bit 3 = start sending).
- R4: When DEPTH or fewer bytes remain, the block pushes all of them. It then raises `cmd_valid_o` with `cmd_code_o` = 8'h0A (bit 3 = start sending, bit 1 = message end).
- R5: After a command beat, no byte is pushed until `pool_ready_i` is seen. The next burst starts in the cycle after that.
- R6: A `pool_ready_i` event with no bytes left raises `confirm_o` for exactly one cycle and drops `busy_o`. No confirm appears at the final command beat itself.
- R7: `underrun_i` or `repeat_i` while waiting returns the frame position to 0 and pushes nothing. The next `pool_ready_i` resends the frame from address 0, even if the last burst had already been sent.
- R8: A rewind event and `pool_ready_i` in the same waiting cycle act as a rewind followed at once by a refill: the next cycle pushes from address 0.
- R9: A request while `link_active_i` is low is dropped. `err_o` pulses for one cycle and nothing is pushed.
- R10: A request of length 0, or of length greater than MAX_LEN, is dropped with a one-cycle `err_o` pulse.
- R11: A request while a frame is in progress is dropped with a one-cycle `err_o` pulse, and the frame in progress continues unchanged.
- R12: `pool_ready_i`, `underrun_i` and `repeat_i` while idle have no effect: no push, no confirm, and the next frame still starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_active_i | input | 1 | Layer-1 link is in the active state |
| req_valid_i | input | 1 | New frame request, one cycle |
| req_len_i | input | LEN_W | Frame length in bytes |
| pool_ready_i | input | 1 | FIFO pool has room again, one cycle |
| underrun_i | input | 1 | Transmit underrun event |
| repeat_i | input | 1 | Message repeat request |
| rd_addr_o | output | LEN_W | Buffer byte address of the current push |
| fifo_push_o | output | 1 | Push one byte into the FIFO |
| cmd_valid_o | output | 1 | Command beat after a burst |
| cmd_code_o | output | 8 | Command value, 8'h08 or 8'h0A |
| confirm_o | output | 1 | Frame completed, one-cycle pulse |
| err_o | output | 1 | Request dropped, one-cycle pulse |
| busy_o | output | 1 | A frame is in progress |

## Verification
The hardest case to reach from the ports is a rewind that lands exactly in the same waiting cycle as a pool-ready event. A second hard case is a repeat that arrives after the final message-end burst, when the frame looks finished but has not yet been confirmed. The stimulus tracks the burst and command beats cycle by cycle, so it knows when the block has entered its waiting state. It then drives the two events together, or drives a repeat before the closing pool-ready. In both cases it checks that the next push starts again at address 0 and that the confirm is held back.

// File: rtl/hdlc_chunk_pkg.sv
package hdlc_chunk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_CMD  = 2'd2,
      ST_WAIT = 2'd3
   } chunk_state_e;

   localparam logic [7:0] CMD_START_TX = 8'h08;
   localparam logic [7:0] CMD_MSG_END  = 8'h02;

endpackage

// File: rtl/hdlc_chunk_sizer.sv
module hdlc_chunk_sizer #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned LEN_W = 9,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic [LEN_W-1:0] frame_len_i,
   input  logic [LEN_W-1:0] offset_i,
   output logic [CW-1:0]    size_o,
   output logic             last_o
);

   localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);

   logic [LEN_W-1:0] remaining;

   always_comb begin
      remaining = frame_len_i - offset_i;
      last_o    = (remaining <= DEPTH_L);
      size_o    = last_o ? CW'(remaining) : CW'(DEPTH);
   end

endmodule

// File: rtl/hdlc_req_gate.sv
module hdlc_req_gate #(
   parameter int unsigned MAX_LEN = 260,
   parameter int unsigned LEN_W   = 9
) (
   input  logic             idle_i,
   input  logic             link_active_i,
   input  logic             req_valid_i,
   input  logic [LEN_W-1:0] req_len_i,
   output logic             accept_o,
   output logic             drop_o
);

   localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

   logic len_ok;

   always_comb begin
      len_ok   = (req_len_i != '0) && (req_len_i <= MAX_L);
      accept_o = req_valid_i && idle_i && link_active_i && len_ok;
      drop_o   = req_valid_i && !accept_o;
   end

endmodule

// File: rtl/hdlc_tx_chunker.sv
module hdlc_tx_chunker
   import hdlc_chunk_pkg::*;
#(
   parameter int unsigned DEPTH   = 32,
   parameter int unsigned MAX_LEN = 260,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             link_active_i,
   input  logic             req_valid_i,
   input  logic [LEN_W-1:0] req_len_i,
   input  logic             pool_ready_i,
   input  logic             underrun_i,
   input  logic             repeat_i,
   output logic [LEN_W-1:0] rd_addr_o,
   output logic             fifo_push_o,
   output logic             cmd_valid_o,
   output logic [7:0]       cmd_code_o,
   output logic             confirm_o,
   output logic             err_o,
   output logic             busy_o
);

   initial begin
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert (MAX_LEN >= DEPTH) else $error("MAX_LEN must cover one FIFO load");
   end

   chunk_state_e     state_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] off_q;
   logic [CW-1:0]    left_q;
   logic             last_q;
   logic             confirm_q;
   logic             err_q;

   logic             accept;
   logic             drop;
   logic             rewind;
   logic [LEN_W-1:0] sz_len;
   logic [LEN_W-1:0] sz_off;
   logic [CW-1:0]    sz_size;
   logic             sz_last;

   assign rewind = (state_q == ST_WAIT) && (underrun_i || repeat_i);

   hdlc_req_gate #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_gate (
      .idle_i        (state_q == ST_IDLE),
      .link_active_i (link_active_i),
      .req_valid_i   (req_valid_i),
      .req_len_i     (req_len_i),
      .accept_o      (accept),
      .drop_o        (drop)
   );

   // One sizer serves both the first burst and every refill.
   always_comb begin
      sz_len = (state_q == ST_IDLE) ? req_len_i : len_q;
      sz_off = (state_q == ST_IDLE || rewind) ? '0 : off_q;
   end

   hdlc_chunk_sizer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_sizer (
      .frame_len_i (sz_len),
      .offset_i    (sz_off),
      .size_o      (sz_size),
      .last_o      (sz_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         len_q     <= '0;
         off_q     <= '0;
         left_q    <= '0;
         last_q    <= 1'b0;
         confirm_q <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         confirm_q <= 1'b0;
         err_q     <= drop;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  len_q   <= req_len_i;
                  off_q   <= '0;
                  left_q  <= sz_size;
                  last_q  <= sz_last;
                  state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               off_q  <= off_q + LEN_W'(1);
               left_q <= left_q - CW'(1);
               if (left_q == CW'(1)) state_q <= ST_CMD;
            end
            ST_CMD: begin
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rewind) begin
                  off_q <= '0;
                  if (pool_ready_i) begin
                     left_q  <= sz_size;
                     last_q  <= sz_last;
                     state_q <= ST_FILL;
                  end
               end else if (pool_ready_i) begin
                  if (off_q == len_q) begin
                     off_q     <= '0;
                     confirm_q <= 1'b1;
                     state_q   <= ST_IDLE;
                  end else begin
                     left_q  <= sz_size;
                     last_q  <= sz_last;
                     state_q <= ST_FILL;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_addr_o   = off_q;
   assign fifo_push_o = (state_q == ST_FILL);
   assign cmd_valid_o = (state_q == ST_CMD);
   assign cmd_code_o  = CMD_START_TX | (last_q ? CMD_MSG_END : 8'h00);
   assign confirm_o   = confirm_q;
   assign err_o       = err_q;
   assign busy_o      = (state_q != ST_IDLE);

   // Consecutive-push counter, used only by the burst-length assertion.
   logic [CW-1:0] burst_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)           burst_cnt <= '0;
      else if (fifo_push_o) burst_cnt <= burst_cnt + CW'(1);
      else                  burst_cnt <= '0;
   end

   AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push_o |-> (burst_cnt < CW'(DEPTH))); // R3

   AST_CMD_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> $past(fifo_push_o)); // R4

   AST_CONFIRM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      confirm_o |-> ($past(pool_ready_i) && !busy_o)); // R6

   AST_REWIND_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && (underrun_i || repeat_i)) |=> (off_q == '0)); // R7

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(req_valid_i)); // R9

   AST_LINK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !link_active_i) |=> (state_q == ST_IDLE)); // R9

   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !pool_ready_i) |=> !fifo_push_o); // R5

endmodule

// File: tb/hdlc_tx_chunker_tb.sv
module hdlc_tx_chunker_tb;

   localparam int unsigned DEPTH   = 32;
   localparam int unsigned MAX_LEN = 260;
   localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);
   localparam int NVEC = 8;
   localparam int unsigned LENS [NVEC] = '{1, 31, 32, 33, 64, 65, 100, 260};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             link_active_i = 1'b0;
   logic             req_valid_i = 1'b0;
   logic [LEN_W-1:0] req_len_i = '0;
   logic             pool_ready_i = 1'b0;
   logic             underrun_i = 1'b0;
   logic             repeat_i = 1'b0;
   logic [LEN_W-1:0] rd_addr_o;
   logic             fifo_push_o;
   logic             cmd_valid_o;
   logic [7:0]       cmd_code_o;
   logic             confirm_o;
   logic             err_o;
   logic             busy_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   hdlc_tx_chunker #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_dut (
      .clk, .rst_n, .link_active_i, .req_valid_i, .req_len_i,
      .pool_ready_i, .underrun_i, .repeat_i, .rd_addr_o, .fifo_push_o,
      .cmd_valid_o, .cmd_code_o, .confirm_o, .err_o, .busy_o
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic request(input int len);
      req_valid_i = 1'b1;
      req_len_i   = LEN_W'(len);
      step();
      req_valid_i = 1'b0;
   endtask

   // Called at the negedge where the first push of a burst is visible.
   task automatic expect_burst(input int base, input int size, input bit last, input string tag);
      int bad = 0;
      for (int k = 0; k < size; k++) begin
         if (!fifo_push_o || rd_addr_o != LEN_W'(base + k)) bad++;
         step();
      end
      check(bad == 0, {tag, " burst pushes/addresses"}, bad, 0);
      check(cmd_valid_o && !fifo_push_o && cmd_code_o == (last ? 8'h0A : 8'h08),
            {tag, " command code"}, int'(cmd_code_o), last ? 32'h0A : 32'h08);
      check(!confirm_o, "R6 no confirm at command beat", int'(confirm_o), 0);
      step();
      check(!fifo_push_o && !cmd_valid_o && busy_o, "R5 waiting for pool ready",
            int'(fifo_push_o), 0);
      step();
      check(!fifo_push_o && busy_o && !confirm_o, "R5 still holding", int'(fifo_push_o), 0);
   endtask

   task automatic pool();
      pool_ready_i = 1'b1;
      step();
      pool_ready_i = 1'b0;
   endtask

   task automatic expect_confirm(input string tag);
      check(confirm_o && !busy_o, {tag, " confirm pulse"}, int'(confirm_o), 1);
      step();
      check(!confirm_o, {tag, " confirm one cycle"}, int'(confirm_o), 0);
   endtask

   // Runs a whole accepted frame from its first burst to the confirm.
   task automatic run_frame(input int len);
      int off = 0;
      int rem = len;
      while (rem > 0) begin
         int sz = (rem > DEPTH) ? DEPTH : rem;
         expect_burst(off, sz, rem <= DEPTH, (rem > DEPTH) ? "R3" : "R4");
         pool();
         off += sz;
         rem -= sz;
      end
      expect_confirm("R6");
   endtask

   initial begin
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(); step();
      check(!busy_o && !fifo_push_o && !cmd_valid_o && !confirm_o && !err_o,
            "R1 reset state", int'(busy_o), 0);
      rst_n = 1'b1;
      link_active_i = 1'b1;
      step();

      // Table walk over frame lengths.
      for (int v = 0; v < NVEC; v++) begin
         request(int'(LENS[v]));
         check(fifo_push_o && rd_addr_o == '0 && !err_o, "R2 accept, first push at 0",
               int'(rd_addr_o), 0);
         run_frame(int'(LENS[v]));
         step();
      end

      // R12: events while idle.
      pool_ready_i = 1'b1; underrun_i = 1'b1; repeat_i = 1'b1;
      step();
      pool_ready_i = 1'b0; underrun_i = 1'b0; repeat_i = 1'b0;
      check(!fifo_push_o && !confirm_o && !busy_o, "R12 idle events ignored",
            int'(busy_o), 0);
      step();
      request(3);
      check(fifo_push_o && rd_addr_o == '0, "R12 next frame starts at 0", int'(rd_addr_o), 0);
      run_frame(3);
      step();

      // R9: link inactive.
      link_active_i = 1'b0;
      request(10);
      check(err_o && !fifo_push_o && !busy_o, "R9 dropped when link down", int'(err_o), 1);
      step();
      check(!err_o && !busy_o, "R9 err one cycle", int'(err_o), 0);
      link_active_i = 1'b1;

      // R10: length bounds.
      request(0);
      check(err_o && !busy_o, "R10 zero length dropped", int'(busy_o), 0);
      step();
      request(MAX_LEN + 1);
      check(err_o && !busy_o, "R10 oversize dropped", int'(busy_o), 0);
      step();

      // R11: request while busy.
      request(40);
      expect_burst(0, 32, 1'b0, "R11 first");
      request(5);
      check(err_o && busy_o && !fifo_push_o, "R11 busy request dropped", int'(err_o), 1);
      pool();
      expect_burst(32, 8, 1'b1, "R11 frame unchanged");
      pool();
      expect_confirm("R11");
      step();

      // R7: underrun mid-frame.
      request(50);
      expect_burst(0, 32, 1'b0, "R7 first");
      underrun_i = 1'b1;
      step();
      underrun_i = 1'b0;
      check(!fifo_push_o && busy_o, "R7 rewind pushes nothing", int'(fifo_push_o), 0);
      pool();
      check(rd_addr_o == '0, "R7 resend from 0 after underrun", int'(rd_addr_o), 0);
      expect_burst(0, 32, 1'b0, "R7 resend");
      pool();
      expect_burst(32, 18, 1'b1, "R7 tail");
      pool();
      expect_confirm("R7");
      step();

      // R7: repeat after final burst.
      request(20);
      expect_burst(0, 20, 1'b1, "R7 short");
      repeat_i = 1'b1;
      step();
      repeat_i = 1'b0;
      pool();
      check(!confirm_o && fifo_push_o && rd_addr_o == '0, "R7 repeat withholds confirm",
            int'(confirm_o), 0);
      expect_burst(0, 20, 1'b1, "R7 repeated");
      pool();
      expect_confirm("R7 repeat");
      step();

      // R8: rewind and pool ready together.
      request(40);
      expect_burst(0, 32, 1'b0, "R8 first");
      underrun_i = 1'b1; pool_ready_i = 1'b1;
      step();
      underrun_i = 1'b0; pool_ready_i = 1'b0;
      check(fifo_push_o && rd_addr_o == '0, "R8 refill from 0 at once", int'(rd_addr_o), 0);
      expect_burst(0, 32, 1'b0, "R8 resend");
      pool();
      expect_burst(32, 8, 1'b1, "R8 tail");
      pool();
      expect_confirm("R8");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule